// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver

This block turns an asynchronous serial line into whole bytes. The line is brought into the system clock domain through a chain of flops. It is then looked at only on a one-cycle enable pulse that the surrounding logic supplies at eight times the bit rate. A falling edge from an idle-high line starts a frame. Half a bit later the receiver checks again that the line is still low, which rejects short glitches. After that it takes every later bit once per bit period, near the middle of the bit.

Eight data bits arrive least significant first. An optional parity bit follows, checked as even or odd according to a static mode input. The last bit is the stop bit. Each finished byte is presented on a valid/ready port, together with three flags: a bad stop bit, a parity mismatch, and a byte lost because the consumer had not taken the previous one.

Top module: `uart_os_rx`

## Requirements
- R1: After reset, rx_valid, err_frame, err_parity and err_overrun are low and rx_data is 0x00.
- R2: A low level first seen on a tick starts a frame only if the line is still low on the fourth tick after that. If it is high by then, the event is dropped and no byte is produced.
- R3: Data bits are sampled every eight ticks, counting from the start-bit check. They are assembled least significant bit first into rx_data.
- R4: parity_mode selects the frame format: 2'b00 and 2'b11 mean no parity bit, 2'b01 means even parity and 2'b10 means odd parity. When parity is enabled, one parity bit sits between bit 7 and the stop bit.
- R5: err_parity is set when the count of ones across the data bits and the parity bit is odd in even mode, or even in odd mode. It is always 0 when no parity is configured.
- R6: err_frame is set when the stop bit is sampled low.
- R7: rx_valid rises with the new byte, and rx_data and rx_valid then hold until a cycle with rx_ready high, after which rx_valid falls.
- R8: All three flags are written in the same cycle rx_valid is set for a frame. They keep their values after the byte is taken, until the next frame completes.
- R9: A frame that completes while rx_valid is high and rx_ready is low replaces rx_data and sets err_overrun. A frame that completes with no byte pending clears err_overrun.
- R10: After the stop-bit sample, a new frame can only begin once the line has been seen high on a tick. A stop bit that stays low therefore produces no extra byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | One-cycle enable at eight times the bit rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| parity_mode | input | 2 | Parity selection (static) |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | Byte available |
| rx_ready | input | 1 | Consumer takes the byte when high with rx_valid |
| err_frame | output | 1 | Stop bit of the last frame was low |
| err_parity | output | 1 | Parity of the last frame did not match |
| err_overrun | output | 1 | Last frame overwrote an unconsumed byte |

## Verification
The assertions assume that parity_mode does not change while a frame is in flight. They also assume that os_tick is a single-cycle pulse that never lasts two cycles in a row. The bench sets parity_mode only between frames, with the line idle. It generates os_tick as a one-cycle pulse every fourth clock, so a bit lasts 32 clocks. Serial bits are driven on whole bit periods whose phase is unrelated to the tick. The centre samples therefore fall well inside each bit, whatever the synchronizer delay.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        PAR_NONE     = 2'b00,
        PAR_EVEN     = 2'b01,
        PAR_ODD      = 2'b10,
        PAR_NONE_ALT = 2'b11
    } par_mode_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              frame_err;
        logic              par_err;
    } rx_result_t;

    function automatic logic par_enabled(input par_mode_t m);
        return (m == PAR_EVEN) || (m == PAR_ODD);
    endfunction

    // ones count over data and parity bit must be even (even mode) or odd (odd mode)
    function automatic logic par_mismatch(input par_mode_t m,
                                          input logic [DATA_W-1:0] d,
                                          input logic pbit);
        logic ones_odd;
        ones_odd = (^d) ^ pbit;
        case (m)
            PAR_EVEN: return ones_odd;
            PAR_ODD:  return ~ones_odd;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic d_sync
);
    logic [STAGES-1:0] chain_q;

    // reset to the idle (high) level of the line
    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import uart_os_rx_pkg::*;
#(
    parameter int OS_RATE = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       line,
    input  par_mode_t  mode,
    output logic       done,
    output rx_result_t result
);
    localparam int CNT_W = $clog2(OS_RATE);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(OS_RATE - 1);
    localparam logic [CNT_W-1:0] CNT_CHECK = CNT_W'(OS_RATE / 2 - 1);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(DATA_W - 1);

    rx_state_t         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] shift_q;
    logic              pbit_q;
    logic              armed_q;
    logic              done_q;
    rx_result_t        result_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            idx_q    <= '0;
            shift_q  <= '0;
            pbit_q   <= 1'b0;
            armed_q  <= 1'b0;
            done_q   <= 1'b0;
            result_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (tick) begin
                case (state_q)
                    ST_IDLE: begin
                        if (line) begin
                            armed_q <= 1'b1;
                        end else if (armed_q) begin
                            state_q <= ST_START;
                            cnt_q   <= '0;
                        end
                    end
                    ST_START: begin
                        if (cnt_q == CNT_CHECK) begin
                            cnt_q <= '0;
                            idx_q <= '0;
                            state_q <= line ? ST_IDLE : ST_DATA;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (cnt_q == CNT_LAST) begin
                            cnt_q   <= '0;
                            shift_q <= {line, shift_q[DATA_W-1:1]};
                            if (idx_q == IDX_LAST)
                                state_q <= par_enabled(mode) ? ST_PAR : ST_STOP;
                            else
                                idx_q <= idx_q + 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (cnt_q == CNT_LAST) begin
                            cnt_q   <= '0;
                            pbit_q  <= line;
                            state_q <= ST_STOP;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (cnt_q == CNT_LAST) begin
                            cnt_q              <= '0;
                            done_q             <= 1'b1;
                            result_q.data      <= shift_q;
                            result_q.frame_err <= ~line;
                            result_q.par_err   <= par_mismatch(mode, shift_q, pbit_q);
                            armed_q            <= 1'b0;
                            state_q            <= ST_IDLE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign done   = done_q;
    assign result = result_q;
endmodule

// File: rtl/rx_out_stage.sv
module rx_out_stage
    import uart_os_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  rx_result_t        result,
    input  logic              ready,
    output logic              valid,
    output logic [DATA_W-1:0] data,
    output logic              frame_err,
    output logic              par_err,
    output logic              overrun
);
    logic              valid_q;
    logic [DATA_W-1:0] data_q;
    logic              ferr_q, perr_q, ovr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            data_q  <= '0;
            ferr_q  <= 1'b0;
            perr_q  <= 1'b0;
            ovr_q   <= 1'b0;
        end else if (done) begin
            valid_q <= 1'b1;
            data_q  <= result.data;
            ferr_q  <= result.frame_err;
            perr_q  <= result.par_err;
            ovr_q   <= valid_q & ~ready;
        end else if (valid_q && ready) begin
            valid_q <= 1'b0;
        end
    end

    assign valid     = valid_q;
    assign data      = data_q;
    assign frame_err = ferr_q;
    assign par_err   = perr_q;
    assign overrun   = ovr_q;
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
    import uart_os_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int OS_RATE     = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       os_tick,
    input  logic       rx_line,
    input  logic [1:0] parity_mode,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    input  logic       rx_ready,
    output logic       err_frame,
    output logic       err_parity,
    output logic       err_overrun
);
    logic       line_s;
    logic       frame_done;
    rx_result_t frame_res;
    par_mode_t  mode;

    assign mode = par_mode_t'(parity_mode);

    rx_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (rx_line),
        .d_sync  (line_s)
    );

    rx_frame_fsm #(.OS_RATE(OS_RATE)) i_fsm (
        .clk    (clk),
        .rst    (rst),
        .tick   (os_tick),
        .line   (line_s),
        .mode   (mode),
        .done   (frame_done),
        .result (frame_res)
    );

    rx_out_stage i_out (
        .clk       (clk),
        .rst       (rst),
        .done      (frame_done),
        .result    (frame_res),
        .ready     (rx_ready),
        .valid     (rx_valid),
        .data      (rx_data),
        .frame_err (err_frame),
        .par_err   (err_parity),
        .overrun   (err_overrun)
    );
endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       os_tick,
    input logic [1:0] parity_mode,
    input logic [7:0] rx_data,
    input logic       rx_valid,
    input logic       rx_ready,
    input logic       err_parity,
    input logic       err_overrun,
    input logic       frame_done
);
    // R7: an offered byte stays offered until taken
    p_valid_hold_r7: assert property (@(posedge clk) disable iff (rst)
        rx_valid && !rx_ready |=> rx_valid);

    // R7 / R9: data only changes under a pending byte when an overrun is flagged
    p_data_stable_r7: assert property (@(posedge clk) disable iff (rst)
        rx_valid && !rx_ready |=> $stable(rx_data) || err_overrun);

    // R7: a handshake with no new frame clears valid
    p_accept_clears_r7: assert property (@(posedge clk) disable iff (rst)
        rx_valid && rx_ready && !frame_done |=> !rx_valid);

    // R9: overrun only appears when a byte was pending and not taken
    p_overrun_cause_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(err_overrun) |-> $past(rx_valid && !rx_ready));

    // R8: the valid bit is raised together with a completed frame
    p_valid_from_frame_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_valid) |-> $past(frame_done));

    // R5: no parity error without a parity bit
    p_no_parity_err_r5: assert property (@(posedge clk) disable iff (rst)
        rx_valid && (parity_mode == 2'b00 || parity_mode == 2'b11) |-> !err_parity);

    // R3: frame completion is paced by the oversampling enable
    p_done_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> $past(os_tick));
endmodule

bind uart_os_rx uart_os_rx_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .os_tick     (os_tick),
    .parity_mode (parity_mode),
    .rx_data     (rx_data),
    .rx_valid    (rx_valid),
    .rx_ready    (rx_ready),
    .err_parity  (err_parity),
    .err_overrun (err_overrun),
    .frame_done  (frame_done)
);

// File: tb/test_uart_os_rx.sv
module test_uart_os_rx;
    localparam int BIT_CLKS = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       os_tick = 1'b0;
    logic       rx_line = 1'b1;
    logic [1:0] parity_mode = 2'b00;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_ready = 1'b0;
    logic       err_frame, err_parity, err_overrun;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    uart_os_rx i_uart_os_rx (
        .clk         (clk),
        .rst         (rst),
        .os_tick     (os_tick),
        .rx_line     (rx_line),
        .parity_mode (parity_mode),
        .rx_data     (rx_data),
        .rx_valid    (rx_valid),
        .rx_ready    (rx_ready),
        .err_frame   (err_frame),
        .err_parity  (err_parity),
        .err_overrun (err_overrun)
    );

    // enable pulse: one cycle in every four, i.e. 8 pulses per 32-clock bit
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            os_tick = 1'b1;
            @(negedge clk);
            os_tick = 1'b0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic hold_line(input logic v, input int clks);
        rx_line = v;
        repeat (clks) @(negedge clk);
    endtask

    // mode: 0 none, 1 even, 2 odd; bad_par flips parity; stop_v is the stop level
    task automatic send_frame(input logic [7:0] d, input logic [1:0] mode,
                              input bit bad_par, input logic stop_v);
        logic pb;
        hold_line(1'b0, BIT_CLKS);
        for (int i = 0; i < 8; i++) hold_line(d[i], BIT_CLKS);
        if (mode == 2'b01 || mode == 2'b10) begin
            pb = (mode == 2'b01) ? ^d : ~^d;
            hold_line(pb ^ bad_par, BIT_CLKS);
        end
        hold_line(stop_v, BIT_CLKS);
        rx_line = 1'b1;
    endtask

    task automatic accept();
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
        @(negedge clk);
    endtask

    task automatic gap();
        hold_line(1'b1, BIT_CLKS);
    endtask

    task automatic t_reset();
        check("R1 valid", rx_valid, 0);
        check("R1 data", rx_data, 8'h00);
        check("R1 frame", err_frame, 0);
        check("R1 parity", err_parity, 0);
        check("R1 overrun", err_overrun, 0);
    endtask

    task automatic t_lsb_first();
        parity_mode = 2'b00;
        gap();
        send_frame(8'h01, 2'b00, 0, 1'b1);
        check("R3 valid 01", rx_valid, 1);
        check("R3 data 01", rx_data, 8'h01);
        check("R5 none no perr", err_parity, 0);
        accept();
        check("R7 cleared", rx_valid, 0);
        gap();
        send_frame(8'h80, 2'b00, 0, 1'b1);
        check("R3 data 80", rx_data, 8'h80);
        accept();
        gap();
        send_frame(8'hA5, 2'b00, 0, 1'b1);
        check("R3 data A5", rx_data, 8'hA5);
        repeat (100) @(negedge clk);
        check("R7 held valid", rx_valid, 1);
        check("R7 held data", rx_data, 8'hA5);
        accept();
        gap();
    endtask

    task automatic t_parity();
        parity_mode = 2'b01;
        gap();
        send_frame(8'h37, 2'b01, 0, 1'b1);
        check("R4 even data", rx_data, 8'h37);
        check("R5 even ok", err_parity, 0);
        accept(); gap();
        send_frame(8'h37, 2'b01, 1, 1'b1);
        check("R5 even bad", err_parity, 1);
        accept();
        repeat (50) @(negedge clk);
        check("R8 perr held", err_parity, 1);
        parity_mode = 2'b10;
        gap();
        send_frame(8'hC8, 2'b10, 0, 1'b1);
        check("R4 odd data", rx_data, 8'hC8);
        check("R8 perr cleared", err_parity, 0);
        accept(); gap();
        send_frame(8'h00, 2'b10, 1, 1'b1);
        check("R5 odd bad", err_parity, 1);
        accept(); gap();
        parity_mode = 2'b11;
        gap();
        send_frame(8'h5A, 2'b11, 0, 1'b1);
        check("R4 mode3 no parity bit", rx_data, 8'h5A);
        check("R4 mode3 perr", err_parity, 0);
        accept();
        parity_mode = 2'b00;
        gap();
    endtask

    task automatic t_framing();
        send_frame(8'h96, 2'b00, 0, 1'b0);
        check("R6 ferr set", err_frame, 1);
        check("R6 data", rx_data, 8'h96);
        accept();
        rx_line = 1'b0;
        repeat (3 * BIT_CLKS) @(negedge clk);
        rx_line = 1'b1;
        repeat (12 * BIT_CLKS) @(negedge clk);
        check("R10 no retrigger", rx_valid, 0);
        check("R8 ferr held", err_frame, 1);
        send_frame(8'h4E, 2'b00, 0, 1'b1);
        check("R6 ferr cleared", err_frame, 0);
        check("R10 next frame", rx_data, 8'h4E);
        accept(); gap();
    endtask

    task automatic t_glitch();
        hold_line(1'b0, 8);
        rx_line = 1'b1;
        repeat (12 * BIT_CLKS) @(negedge clk);
        check("R2 glitch dropped", rx_valid, 0);
        send_frame(8'h3C, 2'b00, 0, 1'b1);
        check("R2 after glitch", rx_data, 8'h3C);
        accept(); gap();
    endtask

    task automatic t_overrun();
        send_frame(8'h11, 2'b00, 0, 1'b1);
        check("R9 first no ovr", err_overrun, 0);
        gap();
        send_frame(8'h22, 2'b00, 0, 1'b1);
        check("R9 overwrite", rx_data, 8'h22);
        check("R9 ovr set", err_overrun, 1);
        accept(); gap();
        send_frame(8'h33, 2'b00, 0, 1'b1);
        check("R9 ovr cleared", err_overrun, 0);
        check("R9 data", rx_data, 8'h33);
        accept(); gap();
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_lsb_first();
        t_parity();
        t_framing();
        t_glitch();
        t_overrun();
        finished = 1'b1;
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end
endmodule